// File: doc/BRIEF.md
# Interval Timer with Snapshot Readout

A 32-bit down-counting interval timer reached through a small word-addressed register bus. Every register holds 16 data bits, so the 32-bit period and the 32-bit running count are each handled as a low half and a high half. Software loads a period, then starts the counter with a command bit. The counter counts down to zero, reloads from the period and raises a timeout flag. In one-shot mode it then halts. In continuous mode it keeps counting.

A live 32-bit count cannot be read safely as two separate 16-bit reads. Software therefore first writes the snapshot-low register, which freezes the current count into the snapshot pair, and then reads the two frozen halves at its own pace. If the period is all ones and continuous mode is on, the block is a free-running 32-bit counter. Software gets a rising time base by inverting the snapshot. An interrupt line follows the timeout flag, gated by an enable bit.

Top module: `snap_itimer`

## Requirements
- R1: Word register index 0 is status, 1 control, 2 period low, 3 period high, 4 snapshot low and 5 snapshot high. Reads return the data in bits 15:0 with the upper bits zero. Indices 6 and 7 read zero and ignore writes.
- R2: A write to period low or period high stops the counter and loads it with {period high, period low}, using the new value of the half just written. The new value appears in the count one cycle later.
- R3: In control, bit 2 is a start command and bit 3 is a stop command. Both are write-only and read as 0. Status bit 1 (run) is set by start and cleared by stop. When both are written together, stop wins.
- R4: While running, the count falls by one each clock. A count of zero is replaced on the next clock by the 32-bit period, so the reload period is P+1 cycles.
- R5: Control bit 1 selects continuous mode. When it is 0, the counter stops at the reload. When it is 1, the counter keeps running.
- R6: Status bit 0 (timeout) is set when a running count is at zero. Any write to status clears it, unless the count reaches zero in the same cycle.
- R7: A write to snapshot low copies the current 32-bit count into the snapshot pair. The pair then holds that value. Writes to snapshot high have no effect.
- R8: Output irq equals timeout AND control bit 0 (interrupt enable). Control bits 1:0 read back as written.
- R9: After reset, all registers read 0, the counter is stopped and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_idx | input | 3 | Word register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_idx (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench takes snapshots on back-to-back cycles and checks the exact count sequence across the zero-to-period reload. A design that is off by one cycle, or that skips the zero state, shows a wrong value there. A one-shot run must leave run clear and the count sitting at the reloaded period, which catches a counter that keeps going or stops at zero. Writing start and stop together while the counter runs must stop it, and a period write must stop a running counter. A write to snapshot high must leave both frozen halves unchanged, and a status write must clear the timeout flag and drop irq.

// File: rtl/snap_itimer_pkg.sv
package snap_itimer_pkg;
  // register word indices
  localparam logic [2:0] IDX_STATUS = 3'd0;
  localparam logic [2:0] IDX_CTRL   = 3'd1;
  localparam logic [2:0] IDX_PER_LO = 3'd2;
  localparam logic [2:0] IDX_PER_HI = 3'd3;
  localparam logic [2:0] IDX_SNP_LO = 3'd4;
  localparam logic [2:0] IDX_SNP_HI = 3'd5;

  // control bit positions
  localparam int CB_IRQ_EN = 0;
  localparam int CB_CONT   = 1;
  localparam int CB_START  = 2;
  localparam int CB_STOP   = 3;

  // status bit positions
  localparam int SB_TIMEOUT = 0;
  localparam int SB_RUN     = 1;
endpackage

// File: rtl/snap_itimer_counter.sv
module snap_itimer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] period,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cont_mode,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             zero_evt
);
  // next count of a running counter
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] per);
    step_count = (cur == '0) ? per : cur - CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_d;
  logic             run_d;

  assign zero_evt = run_q && (cnt_q == '0) && !load_en;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (load_en) begin
      cnt_d = load_val;
      run_d = 1'b0;
    end else begin
      if (run_q) cnt_d = step_count(cnt_q, period);
      if (cmd_stop)                     run_d = 1'b0;
      else if (cmd_start)               run_d = 1'b1;
      else if (zero_evt && !cont_mode)  run_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  // R4
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != '0 && !load_en) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R4
  cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> cnt_q == $past(period));
  // R2
  load_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !run_q && cnt_q == $past(load_val));
  // R3
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !run_q);
  // R5
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !cont_mode && !cmd_start) |=> !run_q);
endmodule

// File: rtl/snap_itimer_regs.sv
module snap_itimer_regs
  import snap_itimer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              run,
  input  logic              zero_evt,
  output logic [CNT_W-1:0]  period,
  output logic              load_en,
  output logic [CNT_W-1:0]  load_val,
  output logic              cmd_start,
  output logic              cmd_stop,
  output logic              cont_mode,
  output logic              irq
);
  logic [HALF_W-1:0] per_lo_q, per_hi_q, snp_lo_q, snp_hi_q;
  logic              irq_en_q, cont_q, timeout_q;
  logic              wr_status, wr_ctrl, wr_plo, wr_phi, wr_snap;
  logic [HALF_W-1:0] wr_half;
  logic              unused_wbits;

  assign unused_wbits = ^bus_wdata;
  assign wr_half   = bus_wdata[HALF_W-1:0];
  assign wr_status = bus_wr && (bus_idx == IDX_STATUS);
  assign wr_ctrl   = bus_wr && (bus_idx == IDX_CTRL);
  assign wr_plo    = bus_wr && (bus_idx == IDX_PER_LO);
  assign wr_phi    = bus_wr && (bus_idx == IDX_PER_HI);
  assign wr_snap   = bus_wr && (bus_idx == IDX_SNP_LO);

  assign cmd_start = wr_ctrl && bus_wdata[CB_START];
  assign cmd_stop  = wr_ctrl && bus_wdata[CB_STOP];
  assign cont_mode = cont_q;
  assign period    = {per_hi_q, per_lo_q};
  assign load_en   = wr_plo || wr_phi;
  assign load_val  = wr_plo ? {per_hi_q, wr_half} : {wr_half, per_lo_q};
  assign irq       = timeout_q && irq_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_lo_q  <= '0;
      per_hi_q  <= '0;
      snp_lo_q  <= '0;
      snp_hi_q  <= '0;
      irq_en_q  <= 1'b0;
      cont_q    <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      if (wr_plo) per_lo_q <= wr_half;
      if (wr_phi) per_hi_q <= wr_half;
      if (wr_snap) begin
        snp_lo_q <= cnt[HALF_W-1:0];
        snp_hi_q <= cnt[CNT_W-1:HALF_W];
      end
      if (wr_ctrl) begin
        irq_en_q <= bus_wdata[CB_IRQ_EN];
        cont_q   <= bus_wdata[CB_CONT];
      end
      if (zero_evt)       timeout_q <= 1'b1;
      else if (wr_status) timeout_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_idx)
      IDX_STATUS: begin
        bus_rdata[SB_TIMEOUT] = timeout_q;
        bus_rdata[SB_RUN]     = run;
      end
      IDX_CTRL: begin
        bus_rdata[CB_IRQ_EN] = irq_en_q;
        bus_rdata[CB_CONT]   = cont_q;
      end
      IDX_PER_LO: bus_rdata[HALF_W-1:0] = per_lo_q;
      IDX_PER_HI: bus_rdata[HALF_W-1:0] = per_hi_q;
      IDX_SNP_LO: bus_rdata[HALF_W-1:0] = snp_lo_q;
      IDX_SNP_HI: bus_rdata[HALF_W-1:0] = snp_hi_q;
      default:    bus_rdata = '0;
    endcase
  end

  // R7
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_snap |=> {snp_hi_q, snp_lo_q} == $past(cnt));
  // R7
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_snap |=> $stable(snp_lo_q) && $stable(snp_hi_q));
  // R6
  timeout_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> timeout_q);
  // R6
  timeout_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && !zero_evt) |=> !timeout_q);
endmodule

// File: rtl/snap_itimer.sv
module snap_itimer #(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [CNT_W-1:0] cnt, period, load_val;
  logic             run, zero_evt, load_en, cmd_start, cmd_stop, cont_mode;

  snap_itimer_regs #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_idx(bus_idx),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt(cnt), .run(run),
    .zero_evt(zero_evt), .period(period), .load_en(load_en),
    .load_val(load_val), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cont_mode(cont_mode), .irq(irq)
  );

  snap_itimer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
    .period(period), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cont_mode(cont_mode), .cnt_q(cnt), .run_q(run), .zero_evt(zero_evt)
  );
endmodule

// File: tb/snap_itimer_tb.sv
module snap_itimer_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_idx = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  snap_itimer u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_idx(bus_idx),
                     .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_idx = idx; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] v);
    bus_idx = idx; #1; v = bus_rdata;
  endtask

  task automatic snap(output logic [31:0] v);
    logic [31:0] lo, hi;
    wr(3'd4, 32'h0);
    rd(3'd4, lo); rd(3'd5, hi);
    v = {hi[15:0], lo[15:0]};
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      check("R9", $sformatf("reg %0d after reset", i), v, 32'h0);
    end
    check("R9", "irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(3'd2, 32'hFFFF_0005);  // upper bits dropped
    wr(3'd3, 32'h0);
    rd(3'd2, v);
    check("R1", "period low upper bits zero", v, 32'h5);
    wr(3'd1, 32'h4);           // start, one-shot
    snap(v); check("R4", "first count", v, 32'd5);
    snap(v); check("R4", "second count", v, 32'd4);
    repeat (12) @(posedge clk);
    #1;
    rd(3'd0, v); check("R5", "one-shot status", v, 32'h1);
    snap(v); check("R5", "one-shot rests at period", v, 32'd5);
    check("R8", "irq gated off", {31'b0, irq}, 32'h0);
    wr(3'd1, 32'h1);
    rd(3'd1, v); check("R8", "ctrl readback", v, 32'h1);
    check("R8", "irq on", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h0);
    rd(3'd0, v); check("R6", "status cleared", v, 32'h0);
    check("R8", "irq off after clear", {31'b0, irq}, 32'h0);
    wr(3'd1, 32'h0);
  endtask

  task automatic t_continuous;
    logic [31:0] v, w;
    logic [31:0] exp [8] = '{3, 2, 1, 0, 3, 2, 1, 0};
    wr(3'd2, 32'h3);
    wr(3'd1, 32'h6);           // start, continuous
    for (int i = 0; i < 8; i++) begin
      snap(v);
      check("R4", $sformatf("continuous count %0d", i), v, exp[i]);
    end
    rd(3'd0, v); check("R5", "continuous keeps running", v, 32'h3);
    wr(3'd1, 32'hA);           // stop, keep continuous
    rd(3'd0, v); check("R3", "run cleared by stop", v & 32'h2, 32'h0);
    rd(3'd1, v); check("R3", "command bits read zero", v, 32'h2);
    snap(v); repeat (4) @(posedge clk); snap(w);
    check("R3", "count frozen while stopped", w, v);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_free_run;
    logic [31:0] v;
    wr(3'd2, 32'hFFFF);
    wr(3'd3, 32'hFFFF);
    wr(3'd1, 32'h6);
    snap(v); check("R4", "free-run up count 0", ~v, 32'd0);
    snap(v); check("R4", "free-run up count 1", ~v, 32'd1);
    snap(v); check("R4", "free-run up count 2", ~v, 32'd2);
  endtask

  task automatic t_period_load;
    logic [31:0] v, w;
    wr(3'd2, 32'h0010);        // counter is running here
    rd(3'd0, v); check("R2", "period write stops", v & 32'h2, 32'h0);
    snap(v); check("R2", "count loaded", v, 32'hFFFF_0010);
    repeat (3) @(posedge clk);
    snap(w); check("R2", "stays loaded", w, 32'hFFFF_0010);
  endtask

  task automatic t_both_cmds;
    logic [31:0] v;
    wr(3'd1, 32'h4);
    rd(3'd0, v); check("R3", "start sets run", v & 32'h2, 32'h2);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd0, v); check("R3", "stop wins over start", v & 32'h2, 32'h0);
    rd(3'd1, v); check("R1", "ctrl upper bits zero", v, 32'h3);
  endtask

  task automatic t_snap_hi;
    logic [31:0] v, lo, hi;
    snap(v);
    wr(3'd5, 32'h0000_ABCD);
    wr(3'd6, 32'h0000_1234);
    rd(3'd4, lo); rd(3'd5, hi);
    check("R7", "snap hi write ignored", {hi[15:0], lo[15:0]}, v);
    rd(3'd6, v); check("R1", "index 6 reads zero", v, 32'h0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_oneshot;
    t_continuous;
    t_free_run;
    t_period_load;
    t_both_cmds;
    t_snap_hi;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule